// File: doc/BRIEF.md
# SPI Byte-Addressed Nonvolatile RAM Slave

This block is the digital core of a serial memory that answers an SPI host in mode 0 (data sampled on the rising clock edge, shifted out on the falling edge). It holds a small byte array and behaves like a ferroelectric RAM. Every write finishes at bus speed, so the device has no busy period and no page structure. A host issues an opcode after pulling the select line low. Depending on the opcode, the host then sends a two-byte address (most significant byte first) and streams data bytes in or out. The internal address steps after every byte and wraps from the last location of the whole array back to zero.

All pins are sampled in the system clock domain through a synchronizer. A pause input lets the host freeze a transfer mid-bit, and a write-guard input can lock the protection settings. A one-byte status word reports the write-arm latch, two protection-range bits and a lock-enable bit. A sleep opcode parks the device until the next select.

Top module: `nvram_spi_slave`

## Requirements
- R1: After reset the output enable `spi_miso_oe` is 0, and it stays 0 whenever `spi_sel_n` is high.
- R2: Opcode 06h sets the write-arm latch and opcode 04h clears it. The latch is visible as status bit 1.
- R3: Opcode 05h returns the status byte first: bit0 = 0 (always ready), bit1 = write-arm latch, bits 3:2 = guard range, bits 5:4 = 0, bit6 = parameter `STAT_B6`, bit7 = lock enable. Every further byte in that frame reads 00h.
- R4: Opcode 02h followed by a 16-bit address stores each data byte when the write-arm latch is set. Address bits above the array width are ignored. Opcode 03h followed by a 16-bit address returns data from that address onward.
- R5: During a burst the address increments after each byte and wraps from DEPTH-1 to 0.
- R6: Opcode 0Bh behaves like 03h, except that one dummy byte follows the address before data is returned.
- R7: The write-arm latch clears when `spi_sel_n` rises after a write frame that reached the end of its address, or after a status-write frame that delivered its data byte.
- R8: Opcode 01h writes status bits 7, 3 and 2 when armed. The guard range 01 blocks the top quarter of the array, 10 blocks the top half and 11 blocks all of it. A write to a blocked address is dropped while the address still advances.
- R9: While status bit 7 is 1 and `wr_guard_n` is low, a status write changes nothing.
- R10: Any other opcode, for example 42h or D8h, has no effect on the latch, status or array.
- R11: After a frame carrying B9h, the device sleeps. The next frame is ignored entirely, with no output and no effect. The frame after that works normally.
- R12: `pause_n` changes are taken only while `spi_clk` is low. While paused, `spi_miso_oe` is 0, and clock edges and select toggles are ignored. Releasing the pause resumes the transfer at the same bit.
- R13: A rise of `spi_sel_n` ends any command. A partial byte is discarded and the next frame starts with an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sel_n | input | 1 | Active-low slave select |
| spi_clk | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data in |
| pause_n | input | 1 | Active-low transfer pause |
| wr_guard_n | input | 1 | Active-low status lock input |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the serial data pad |

## Verification
Several properties are checked on every cycle: the address steps by one after each burst byte, the write-arm latch drops at the end of a completed write frame, trailing status bytes are zero, the output stays quiet in the frame right after sleep, and the shift register holds still while paused. The bench scenarios cover the behaviours that only show up across whole frames: the full-array write and readback with wrap, the fast-read dummy slot, the guard-range boundaries, the lock against status writes, ignored opcodes, aborted frames, and a pause with clock and select toggling in the middle of a read.

// File: rtl/nvram_pkg.sv
package nvram_pkg;

   localparam logic [7:0] OP_ARM     = 8'h06;
   localparam logic [7:0] OP_DISARM  = 8'h04;
   localparam logic [7:0] OP_STAT_RD = 8'h05;
   localparam logic [7:0] OP_STAT_WR = 8'h01;
   localparam logic [7:0] OP_READ    = 8'h03;
   localparam logic [7:0] OP_WRITE   = 8'h02;
   localparam logic [7:0] OP_FREAD   = 8'h0B;
   localparam logic [7:0] OP_SLEEP   = 8'hB9;

   typedef enum logic [3:0] {
      ST_OPC,
      ST_ADH,
      ST_ADL,
      ST_DUMMY,
      ST_RD,
      ST_WR,
      ST_SRRD,
      ST_SRWR,
      ST_SKIP
   } cmd_state_e;

   typedef enum logic [1:0] {
      K_READ,
      K_FREAD,
      K_WRITE
   } xfer_kind_e;

   // top2 holds the two most significant address bits
   function automatic logic range_blocked(input logic [1:0] sel, input logic [1:0] top2);
      return (sel == 2'b11) || (sel == 2'b10 && top2[1]) || (sel == 2'b01 && top2 == 2'b11);
   endfunction

endpackage

// File: rtl/nvram_spi_front.sv
module nvram_spi_front #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_clk,
   input  logic spi_sel_n,
   input  logic spi_mosi,
   input  logic pause_n,
   input  logic wr_guard_n,
   output logic clk_rise,
   output logic clk_fall,
   output logic mosi_s,
   output logic guard_s,
   output logic frame_idle,
   output logic held
);

   localparam int NPIN = 5;
   localparam logic [NPIN-1:0] PIN_RST = 5'b01011;

   logic [SYNC_STAGES-1:0][NPIN-1:0] stg;
   logic sclk_l, sel_l, pause_l;
   logic sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= {SYNC_STAGES{PIN_RST}};
      end else begin
         stg <= {stg[SYNC_STAGES-2:0], {spi_clk, spi_sel_n, spi_mosi, pause_n, wr_guard_n}};
      end
   end

   assign sclk_l  = stg[SYNC_STAGES-1][4];
   assign sel_l   = stg[SYNC_STAGES-1][3];
   assign mosi_s  = stg[SYNC_STAGES-1][2];
   assign pause_l = stg[SYNC_STAGES-1][1];
   assign guard_s = stg[SYNC_STAGES-1][0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         held   <= 1'b0;
      end else begin
         sclk_d <= sclk_l;
         if (!held && !sclk_l && !pause_l)
            held <= 1'b1;
         else if (held && !sclk_l && pause_l)
            held <= 1'b0;
      end
   end

   assign clk_rise   = sclk_l && !sclk_d && !held;
   assign clk_fall   = !sclk_l && sclk_d && !held;
   assign frame_idle = sel_l && !held;

   AST_PAUSE_ON_LOW_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      (held != $past(held)) |-> !$past(sclk_l)); // R12

endmodule

// File: rtl/nvram_array.sv
module nvram_array #(
   parameter int DEPTH  = 256,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [7:0]        wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [7:0]        rdata
);

   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/nvram_cmd_ctl.sv
module nvram_cmd_ctl
   import nvram_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter bit STAT_B6  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_rise,
   input  logic              clk_fall,
   input  logic              mosi_s,
   input  logic              guard_s,
   input  logic              frame_idle,
   input  logic              held,
   input  logic [7:0]        rd_data,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_waddr,
   output logic [7:0]        mem_wdata,
   output logic [ADDR_W-1:0] mem_raddr,
   output logic              miso_q,
   output logic              miso_oe
);

   cmd_state_e  state;
   xfer_kind_e  kind;
   logic [2:0]  bit_cnt;
   logic [6:0]  rx_sh;
   logic [ADDR_W-1:0] addr;
   logic        wr_latch;
   logic [1:0]  guard_sel;
   logic        sr_lock;
   logic        sleep_req, asleep, wake_frame, in_frame, wr_done;
   logic [7:0]  tx_sh, tx_next;
   logic        tx_load, tx_on;

   logic [7:0]        rx_byte;
   logic              byte_done;
   logic [ADDR_W-1:0] full_adl;
   logic [7:0]        stat_byte;

   assign rx_byte   = {rx_sh, mosi_s};
   assign byte_done = clk_rise && in_frame && (bit_cnt == 3'd7);
   assign full_adl  = addr | ADDR_W'(rx_byte);
   assign stat_byte = {sr_lock, STAT_B6, 2'b00, guard_sel, wr_latch, 1'b0};

   assign mem_raddr = (state == ST_ADL) ? full_adl : addr;
   assign mem_waddr = addr;
   assign mem_wdata = rx_byte;
   assign mem_we    = byte_done && !frame_idle && (state == ST_WR) && wr_latch
                      && !range_blocked(guard_sel, addr[ADDR_W-1 -: 2]);

   assign miso_q  = tx_sh[7];
   assign miso_oe = tx_on && in_frame && !held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_OPC;
         kind       <= K_READ;
         bit_cnt    <= '0;
         rx_sh      <= '0;
         addr       <= '0;
         wr_latch   <= 1'b0;
         guard_sel  <= 2'b00;
         sr_lock    <= 1'b0;
         sleep_req  <= 1'b0;
         asleep     <= 1'b0;
         wake_frame <= 1'b0;
         in_frame   <= 1'b0;
         wr_done    <= 1'b0;
         tx_sh      <= '0;
         tx_next    <= '0;
         tx_load    <= 1'b0;
         tx_on      <= 1'b0;
      end else if (frame_idle) begin
         if (in_frame) begin
            if (wr_done)   wr_latch <= 1'b0;
            if (sleep_req) asleep   <= 1'b1;
         end
         state      <= ST_OPC;
         bit_cnt    <= '0;
         in_frame   <= 1'b0;
         wake_frame <= 1'b0;
         wr_done    <= 1'b0;
         sleep_req  <= 1'b0;
         tx_load    <= 1'b0;
         tx_on      <= 1'b0;
      end else begin
         if (!in_frame) begin
            in_frame <= 1'b1;
            if (asleep) begin
               asleep     <= 1'b0;
               wake_frame <= 1'b1;
            end
         end
         if (clk_rise && in_frame) begin
            bit_cnt <= bit_cnt + 3'd1;
            rx_sh   <= {rx_sh[5:0], mosi_s};
         end
         if (byte_done) begin
            case (state)
               ST_OPC: begin
                  state <= ST_SKIP;
                  if (!wake_frame) begin
                     case (rx_byte)
                        OP_ARM:     wr_latch <= 1'b1;
                        OP_DISARM:  wr_latch <= 1'b0;
                        OP_STAT_RD: begin
                           tx_next <= stat_byte;
                           tx_load <= 1'b1;
                           state   <= ST_SRRD;
                        end
                        OP_STAT_WR: state <= ST_SRWR;
                        OP_READ:  begin kind <= K_READ;  state <= ST_ADH; end
                        OP_FREAD: begin kind <= K_FREAD; state <= ST_ADH; end
                        OP_WRITE: begin kind <= K_WRITE; state <= ST_ADH; end
                        OP_SLEEP:   sleep_req <= 1'b1;
                        default: ;
                     endcase
                  end
               end
               ST_ADH: begin
                  addr  <= ADDR_W'({rx_byte, 8'h00});
                  state <= ST_ADL;
               end
               ST_ADL: begin
                  case (kind)
                     K_READ: begin
                        tx_next <= rd_data;
                        tx_load <= 1'b1;
                        addr    <= full_adl + 1'b1;
                        state   <= ST_RD;
                     end
                     K_FREAD: begin
                        addr  <= full_adl;
                        state <= ST_DUMMY;
                     end
                     default: begin
                        addr    <= full_adl;
                        wr_done <= 1'b1;
                        state   <= ST_WR;
                     end
                  endcase
               end
               ST_DUMMY, ST_RD: begin
                  tx_next <= rd_data;
                  tx_load <= 1'b1;
                  addr    <= addr + 1'b1;
                  state   <= ST_RD;
               end
               ST_WR: addr <= addr + 1'b1;
               ST_SRRD: begin
                  tx_next <= 8'h00;
                  tx_load <= 1'b1;
               end
               ST_SRWR: begin
                  if (wr_latch && !(sr_lock && !guard_s)) begin
                     sr_lock   <= rx_byte[7];
                     guard_sel <= rx_byte[3:2];
                  end
                  wr_done <= 1'b1;
                  state   <= ST_SKIP;
               end
               default: ;
            endcase
         end
         if (clk_fall && in_frame) begin
            if (tx_load) begin
               tx_sh   <= tx_next;
               tx_load <= 1'b0;
               tx_on   <= 1'b1;
            end else begin
               tx_sh <= {tx_sh[6:0], 1'b0};
            end
         end
      end
   end

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && !frame_idle && (state == ST_RD || state == ST_WR))
      |=> (addr == $past(addr) + 1'b1)); // R5

   AST_ARM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_idle && in_frame && wr_done) |=> !wr_latch); // R7

   AST_STAT_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && !frame_idle && state == ST_SRRD) |=> (tx_load && tx_next == 8'h00)); // R3

   AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      wake_frame |-> !miso_oe); // R11

endmodule

// File: rtl/nvram_spi_slave.sv
module nvram_spi_slave #(
   parameter int DEPTH       = 256,
   parameter int SYNC_STAGES = 2,
   parameter bit STAT_B6     = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sel_n,
   input  logic spi_clk,
   input  logic spi_mosi,
   input  logic pause_n,
   input  logic wr_guard_n,
   output logic spi_miso,
   output logic spi_miso_oe
);

   localparam int ADDR_W = $clog2(DEPTH);

   if (DEPTH < 4 || DEPTH > 65536 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two from 4 to 65536");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic clk_rise, clk_fall, mosi_s, guard_s, frame_idle, held;
   logic mem_we;
   logic [ADDR_W-1:0] mem_waddr, mem_raddr;
   logic [7:0] mem_wdata, mem_rdata;

   nvram_spi_front #(
      .SYNC_STAGES(SYNC_STAGES)
   ) front_i (
      .clk(clk), .rst_n(rst_n),
      .spi_clk(spi_clk), .spi_sel_n(spi_sel_n), .spi_mosi(spi_mosi),
      .pause_n(pause_n), .wr_guard_n(wr_guard_n),
      .clk_rise(clk_rise), .clk_fall(clk_fall), .mosi_s(mosi_s),
      .guard_s(guard_s), .frame_idle(frame_idle), .held(held)
   );

   nvram_cmd_ctl #(
      .ADDR_W(ADDR_W), .STAT_B6(STAT_B6)
   ) ctl_i (
      .clk(clk), .rst_n(rst_n),
      .clk_rise(clk_rise), .clk_fall(clk_fall), .mosi_s(mosi_s),
      .guard_s(guard_s), .frame_idle(frame_idle), .held(held),
      .rd_data(mem_rdata),
      .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
      .mem_raddr(mem_raddr),
      .miso_q(spi_miso), .miso_oe(spi_miso_oe)
   );

   nvram_array #(
      .DEPTH(DEPTH), .ADDR_W(ADDR_W)
   ) array_i (
      .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
      .raddr(mem_raddr), .rdata(mem_rdata)
   );

   AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (held && $past(held)) |-> $stable(spi_miso)); // R12

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_idle && $past(frame_idle)) |-> !spi_miso_oe); // R1

endmodule

// File: tb/nvram_spi_slave_tb_top.sv
module nvram_spi_slave_tb_top;

   localparam int DEPTH = 256;
   localparam int HALF  = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_sel_n = 1'b1, spi_clk = 1'b0, spi_mosi = 1'b0;
   logic pause_n = 1'b1, wr_guard_n = 1'b1;
   logic spi_miso, spi_miso_oe;

   int total = 0;
   int fails = 0;
   logic [7:0] exp_mem [DEPTH];
   logic [7:0] rb, s0, s1;
   logic oe_seen;

   always #4 clk = ~clk;

   nvram_spi_slave #(.DEPTH(DEPTH), .SYNC_STAGES(2), .STAT_B6(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .spi_sel_n(spi_sel_n), .spi_clk(spi_clk),
      .spi_mosi(spi_mosi), .pause_n(pause_n), .wr_guard_n(wr_guard_n),
      .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [7:0] pat(input int i, input int seed);
      return 8'((i * 37 + seed) & 255);
   endfunction

   task automatic do_pause();
      pause_n = 1'b0;
      wait_clk(6);
      chk("R12 paused output off", {31'd0, spi_miso_oe}, 32'd0);
      for (int k = 0; k < 3; k++) begin
         spi_clk = 1'b1; wait_clk(3);
         spi_clk = 1'b0; wait_clk(3);
      end
      spi_sel_n = 1'b1; wait_clk(6);
      spi_sel_n = 1'b0; wait_clk(6);
      chk("R12 still paused after toggles", {31'd0, spi_miso_oe}, 32'd0);
      pause_n = 1'b1;
      wait_clk(6);
   endtask

   task automatic spi_bits(input logic [7:0] tx, input int nbits, input int pause_at,
                           output logic [7:0] rx, output logic oe);
      rx = '0;
      oe = 1'b0;
      for (int b = 7; b > 7 - nbits; b--) begin
         if (b == pause_at) do_pause();
         spi_mosi = tx[b];
         wait_clk(HALF);
         rx[b] = spi_miso;
         oe    = oe | spi_miso_oe;
         spi_clk = 1'b1;
         wait_clk(HALF);
         spi_clk = 1'b0;
      end
   endtask

   task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
      logic o;
      spi_bits(tx, 8, -1, rx, o);
   endtask

   task automatic sel_on();
      spi_sel_n = 1'b0;
      wait_clk(HALF);
   endtask

   task automatic sel_off();
      wait_clk(HALF);
      spi_sel_n = 1'b1;
      wait_clk(2 * HALF);
   endtask

   task automatic op1(input logic [7:0] op);
      logic [7:0] d;
      sel_on(); xb(op, d); sel_off();
   endtask

   task automatic stat_rd(output logic [7:0] a, output logic [7:0] b);
      logic [7:0] d;
      sel_on(); xb(8'h05, d); xb(8'h00, a); xb(8'h00, b); sel_off();
   endtask

   task automatic stat_wr(input logic [7:0] v);
      logic [7:0] d;
      sel_on(); xb(8'h01, d); xb(v, d); sel_off();
   endtask

   task automatic wr_burst(input logic [15:0] a, input int n, input int seed);
      logic [7:0] d;
      sel_on(); xb(8'h02, d); xb(a[15:8], d); xb(a[7:0], d);
      for (int i = 0; i < n; i++) xb(pat(i, seed), d);
      sel_off();
   endtask

   task automatic rd_check(input string req, input logic [7:0] op, input logic [15:0] a, input int n);
      logic [7:0] d;
      sel_on(); xb(op, d); xb(a[15:8], d); xb(a[7:0], d);
      if (op == 8'h0B) xb(8'h00, d);
      for (int i = 0; i < n; i++) begin
         xb(8'h00, d);
         chk(req, {24'd0, d}, {24'd0, exp_mem[(int'(a) + i) % DEPTH]});
      end
      sel_off();
   endtask

   function automatic bit blocked(input int g, input int a);
      return (g == 3) || (g == 2 && a >= DEPTH / 2) || (g == 1 && a >= 3 * DEPTH / 4);
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      total++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      // R1 reset state
      chk("R1 output off after reset", {31'd0, spi_miso_oe}, 32'd0);
      stat_rd(s0, s1);
      chk("R3 status after reset", {24'd0, s0}, 32'h40);
      chk("R3 second status byte", {24'd0, s1}, 32'h00);
      chk("R1 output off when deselected", {31'd0, spi_miso_oe}, 32'd0);

      // R2 arm and disarm
      op1(8'h06); stat_rd(s0, s1);
      chk("R2 latch set", {24'd0, s0}, 32'h42);
      op1(8'h04); stat_rd(s0, s1);
      chk("R2 latch cleared", {24'd0, s0}, 32'h40);

      // R4 R5 full array fill and readback with wrap
      op1(8'h06);
      wr_burst(16'h0000, DEPTH, 11);
      for (int i = 0; i < DEPTH; i++) exp_mem[i] = pat(i, 11);
      stat_rd(s0, s1);
      chk("R7 latch cleared after write", {24'd0, s0}, 32'h40);
      rd_check("R4 R5 full readback", 8'h03, 16'h0000, DEPTH + 4);

      // R4 write without latch is dropped
      wr_burst(16'h0005, 1, 99);
      rd_check("R4 unarmed write dropped", 8'h03, 16'h0005, 1);

      // R5 write burst wraps at top, upper address bits ignored
      op1(8'h06);
      wr_burst(16'h01FE, 3, 200);
      for (int i = 0; i < 3; i++) exp_mem[(254 + i) % DEPTH] = pat(i, 200);
      rd_check("R5 write wrap", 8'h03, 16'h00FE, 3);

      // R6 fast read
      rd_check("R6 fast read", 8'h0B, 16'h0010, 4);

      // R10 unknown opcodes
      op1(8'h06);
      sel_on(); xb(8'h42, rb); xb(8'h00, rb); xb(8'h00, rb); xb(8'h55, rb); sel_off();
      sel_on(); xb(8'hD8, rb); xb(8'h00, rb); xb(8'h00, rb); sel_off();
      stat_rd(s0, s1);
      chk("R10 status unchanged", {24'd0, s0}, 32'h42);
      rd_check("R10 array unchanged", 8'h03, 16'h0000, 2);

      // R13 partial frame aborted
      sel_on(); spi_bits(8'h04, 5, -1, rb, oe_seen); sel_off();
      stat_rd(s0, s1);
      chk("R13 partial opcode ignored", {24'd0, s0}, 32'h42);
      op1(8'h04);

      // R8 guard ranges
      for (int g = 1; g <= 3; g++) begin
         op1(8'h06);
         stat_wr(8'(g << 2));
         stat_rd(s0, s1);
         chk("R8 guard bits stored", {24'd0, s0}, 32'h40 | (g << 2));
         for (int k = 0; k < 6; k++) begin
            int a;
            a = (k == 0) ? 0 : (k == 1) ? 127 : (k == 2) ? 128 :
                (k == 3) ? 191 : (k == 4) ? 192 : 255;
            op1(8'h06);
            wr_burst(16'(a), 1, g * 50 + a);
            if (!blocked(g, a)) exp_mem[a] = pat(0, g * 50 + a);
            rd_check("R8 guarded write", 8'h03, 16'(a), 1);
         end
      end
      // R8 address still advances over blocked bytes
      op1(8'h06);
      stat_wr(8'h04);
      op1(8'h06);
      wr_burst(16'h00BE, 4, 77);
      exp_mem[190] = pat(0, 77);
      exp_mem[191] = pat(1, 77);
      rd_check("R8 burst across guard edge", 8'h03, 16'h00BE, 4);
      op1(8'h06);
      stat_wr(8'h00);

      // R9 lock against status write
      op1(8'h06); stat_wr(8'h80); stat_rd(s0, s1);
      chk("R9 lock bit set", {24'd0, s0}, 32'hC0);
      wr_guard_n = 1'b0;
      op1(8'h06); stat_wr(8'h0C); stat_rd(s0, s1);
      chk("R9 locked status write ignored", {24'd0, s0}, 32'hC0);
      wr_guard_n = 1'b1;
      op1(8'h06); stat_wr(8'h00); stat_rd(s0, s1);
      chk("R9 unlocked status write", {24'd0, s0}, 32'h40);

      // R11 sleep
      op1(8'hB9);
      sel_on(); spi_bits(8'h06, 8, -1, rb, oe_seen); spi_bits(8'h00, 8, -1, rb, oe_seen); sel_off();
      chk("R11 wake frame silent", {31'd0, oe_seen}, 32'd0);
      sel_on(); xb(8'h05, rb); spi_bits(8'h00, 8, -1, s0, oe_seen); sel_off();
      chk("R11 wake frame ignored", {24'd0, s0}, 32'h40);
      chk("R11 normal after wake", {31'd0, oe_seen}, 32'd1);

      // R12 pause in the middle of a read
      sel_on(); xb(8'h03, rb); xb(8'h00, rb); xb(8'h20, rb);
      xb(8'h00, rb);
      chk("R12 byte before pause", {24'd0, rb}, {24'd0, exp_mem[32]});
      spi_bits(8'h00, 8, 4, rb, oe_seen);
      chk("R12 byte across pause", {24'd0, rb}, {24'd0, exp_mem[33]});
      xb(8'h00, rb);
      chk("R12 byte after pause", {24'd0, rb}, {24'd0, exp_mem[34]});
      sel_off();

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule